// File: doc/BRIEF.md
# Write-Once System Options Register

This block holds one 8-bit system configuration register on a memory-mapped bus. After any reset it accepts exactly one write. That write sets a lock, and every later write is dropped until the next reset. The register can be read at any time.

The stored fields drive several controls:
- a two-bit watchdog timeout select;
- a stop-mode permission;
- a pin-pair selector for the serial bus;
- a function select for the shared debug pin;
- a function select for the shared reset pin, together with that pin's pull-up enable.

The block also guards stop requests from the core. If stop mode is not permitted, a stop request produces a one-cycle illegal-opcode reset request instead.

Three synchronous reset-type inputs reload the register: power-on, low-voltage and other internal reset. Most fields return to fixed values on any of them. The reset-pin function bit is cleared only by a power-on reset and keeps its value through the other two. Any reset re-arms the write lock.

Top module: `sysopt_reg`

## Requirements
- R1: With the lock clear and no reset input active, a write stores the write data and sets the lock. The new contents are visible on the read port after the next clock edge.
- R2: With the lock set, writes leave the contents unchanged, whatever the data. This holds until the next reset.
- R3: A first write whose data equals the current contents still sets the lock.
- R4: The read port always returns the current contents, locked or not. The field layout is: bits 7:6 timeout select, bit 5 stop permission, bit 4 spare, bit 2 bus pin-pair select, bit 1 debug-pin function, bit 0 reset-pin function. Bit 3 always reads 0, even when it is written with 1.
- R5: The spare bit 4 is stored by the first write and reads back as written. It changes none of the control outputs.
- R6: Any reset input clears the lock and loads these values: timeout select 11, stop permission 0, spare 0, pin-pair select 0, debug-pin function 1.
- R7: A power-on reset clears the reset-pin function bit. Low-voltage and internal resets keep its previous value.
- R8: If power-on reset is asserted together with another reset input, the power-on values apply.
- R9: With stop permission 0, a rising edge on the stop request raises the illegal-opcode reset request for exactly one cycle, in the cycle after the edge. With stop permission 1, no request is raised.
- R10: The control outputs follow the stored fields. `rst_pullup_en` equals the reset-pin function bit.
- R11: When a stop request edge and a first write arrive in the same cycle, the stop request is judged against the stop permission held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| lvd_rst | input | 1 | Low-voltage reset, synchronous, active high |
| int_rst | input | 1 | Other internal reset, synchronous, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Current register contents |
| locked | output | 1 | Write lock flag |
| stop_req | input | 1 | Stop instruction signal from the core |
| illegal_rst_req | output | 1 | One-cycle illegal-opcode reset request |
| wdog_tsel | output | 2 | Watchdog timeout select |
| stop_en | output | 1 | Stop mode permitted |
| bus_pin_alt | output | 1 | 1 selects the alternate serial-bus pin pair |
| dbg_pin_en | output | 1 | Shared pin acts as debug pin |
| rst_pin_en | output | 1 | Shared pin acts as reset input |
| rst_pullup_en | output | 1 | Pull-up enable for the reset pin |

## Verification
The first write and the stop guard can act in the same cycle. This happens when the write that grants stop permission coincides with a stop request edge. The bench provokes it right after a power-on reset by driving a write of 0x20 and a rising stop request on the same clock. It judges the result by expecting the illegal request to fire, because the old permission was 0, while the read port shows the new contents. A second case drives power-on and low-voltage reset together and expects the power-on values.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;

    localparam int OPT_W  = 8;
    localparam int TSEL_W = 2;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_POR  = 2'd1,
        RK_LVD  = 2'd2,
        RK_INT  = 2'd3
    } rst_kind_e;

    typedef struct packed {
        logic [TSEL_W-1:0] tsel;
        logic              stop_ok;
        logic              spare;
        logic              bus_alt;
        logic              dbg_fn;
        logic              rst_fn;
    } opt_t;

    localparam logic [TSEL_W-1:0] TSEL_INIT = '1;

    function automatic logic [OPT_W-1:0] opt_pack(input opt_t o);
        return {o.tsel, o.stop_ok, o.spare, 1'b0, o.bus_alt, o.dbg_fn, o.rst_fn};
    endfunction

    function automatic opt_t opt_unpack(input logic [OPT_W-1:0] d);
        opt_t o;
        o.tsel    = d[7:6];
        o.stop_ok = d[5];
        o.spare   = d[4];
        o.bus_alt = d[2];
        o.dbg_fn  = d[1];
        o.rst_fn  = d[0];
        return o;
    endfunction

    function automatic opt_t reset_image(input rst_kind_e k, input opt_t prev);
        opt_t o;
        o.tsel    = TSEL_INIT;
        o.stop_ok = 1'b0;
        o.spare   = 1'b0;
        o.bus_alt = 1'b0;
        o.dbg_fn  = 1'b1;
        o.rst_fn  = (k == RK_POR) ? 1'b0 : prev.rst_fn;
        return o;
    endfunction

endpackage

// File: rtl/sysopt_rst_decode.sv
module sysopt_rst_decode
    import sysopt_pkg::*;
(
    input  logic      por_rst,
    input  logic      lvd_rst,
    input  logic      int_rst,
    output rst_kind_e kind,
    output logic      any_rst
);
    always_comb begin
        if (por_rst)      kind = RK_POR;
        else if (lvd_rst) kind = RK_LVD;
        else if (int_rst) kind = RK_INT;
        else              kind = RK_NONE;
        any_rst = (kind != RK_NONE);
    end
endmodule

// File: rtl/sysopt_store.sv
module sysopt_store
    import sysopt_pkg::*;
(
    input  logic             clk,
    input  rst_kind_e        kind,
    input  logic             wr,
    input  logic [OPT_W-1:0] wdata,
    output opt_t             opt,
    output logic             locked
);
    always_ff @(posedge clk) begin
        if (kind != RK_NONE) begin
            opt    <= reset_image(kind, opt);
            locked <= 1'b0;
        end else if (wr && !locked) begin
            opt    <= opt_unpack(wdata);
            locked <= 1'b1;
        end
    end
endmodule

// File: rtl/sysopt_stop_guard.sv
module sysopt_stop_guard (
    input  logic clk,
    input  logic any_rst,
    input  logic stop_req,
    input  logic stop_ok,
    output logic illegal
);
    logic stop_q;

    always_ff @(posedge clk) begin
        if (any_rst) begin
            stop_q  <= 1'b0;
            illegal <= 1'b0;
        end else begin
            stop_q  <= stop_req;
            illegal <= stop_req && !stop_q && !stop_ok;
        end
    end
endmodule

// File: rtl/sysopt_reg.sv
module sysopt_reg
    import sysopt_pkg::*;
(
    input  logic              clk,
    input  logic              por_rst,
    input  logic              lvd_rst,
    input  logic              int_rst,
    input  logic              bus_wr,
    input  logic [OPT_W-1:0]  bus_wdata,
    output logic [OPT_W-1:0]  bus_rdata,
    output logic              locked,
    input  logic              stop_req,
    output logic              illegal_rst_req,
    output logic [TSEL_W-1:0] wdog_tsel,
    output logic              stop_en,
    output logic              bus_pin_alt,
    output logic              dbg_pin_en,
    output logic              rst_pin_en,
    output logic              rst_pullup_en
);
    rst_kind_e kind;
    logic      any_rst;
    opt_t      opt;

    sysopt_rst_decode u_dec (
        .por_rst (por_rst),
        .lvd_rst (lvd_rst),
        .int_rst (int_rst),
        .kind    (kind),
        .any_rst (any_rst)
    );

    sysopt_store u_store (
        .clk    (clk),
        .kind   (kind),
        .wr     (bus_wr),
        .wdata  (bus_wdata),
        .opt    (opt),
        .locked (locked)
    );

    sysopt_stop_guard u_guard (
        .clk      (clk),
        .any_rst  (any_rst),
        .stop_req (stop_req),
        .stop_ok  (opt.stop_ok),
        .illegal  (illegal_rst_req)
    );

    assign bus_rdata     = opt_pack(opt);
    assign wdog_tsel     = opt.tsel;
    assign stop_en       = opt.stop_ok;
    assign bus_pin_alt   = opt.bus_alt;
    assign dbg_pin_en    = opt.dbg_fn;
    assign rst_pin_en    = opt.rst_fn;
    assign rst_pullup_en = opt.rst_fn;
endmodule

// File: rtl/sysopt_reg_chk.sv
module sysopt_reg_chk (
    input logic       clk,
    input logic       por_rst,
    input logic       lvd_rst,
    input logic       int_rst,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       locked,
    input logic       stop_req,
    input logic       stop_en,
    input logic       illegal_rst_req,
    input logic       rst_pin_en
);
    bit   seen_por = 1'b0;
    logic any_rst;

    assign any_rst = por_rst || lvd_rst || int_rst;

    always_ff @(posedge clk) begin
        if (por_rst) seen_por <= 1'b1;
    end

    // R1
    first_wr_chk: assert property (@(posedge clk) disable iff (!seen_por)
        (!any_rst && !locked && bus_wr) |=> (locked && bus_rdata == ($past(bus_wdata) & 8'hF7)));

    // R2
    locked_hold_chk: assert property (@(posedge clk) disable iff (!seen_por)
        (!any_rst && locked) |=> $stable(bus_rdata));

    // R6
    reset_load_chk: assert property (@(posedge clk) disable iff (!seen_por)
        any_rst |=> (!locked && bus_rdata[7:1] == 7'b1100_001));

    // R7
    por_clear_chk: assert property (@(posedge clk) disable iff (!seen_por)
        por_rst |=> !rst_pin_en);

    // R7
    soft_keep_chk: assert property (@(posedge clk) disable iff (!seen_por)
        (!por_rst && (lvd_rst || int_rst)) |=> (rst_pin_en == $past(rst_pin_en)));

    // R9
    pulse_width_chk: assert property (@(posedge clk) disable iff (!seen_por)
        illegal_rst_req |=> !illegal_rst_req);

    // R9
    stop_allowed_chk: assert property (@(posedge clk) disable iff (!seen_por)
        (stop_en && !any_rst) |=> !illegal_rst_req);

    // R4
    bit3_zero_chk: assert property (@(posedge clk) disable iff (!seen_por)
        bus_rdata[3] == 1'b0);
endmodule

bind sysopt_reg sysopt_reg_chk u_chk (
    .clk             (clk),
    .por_rst         (por_rst),
    .lvd_rst         (lvd_rst),
    .int_rst         (int_rst),
    .bus_wr          (bus_wr),
    .bus_wdata       (bus_wdata),
    .bus_rdata       (bus_rdata),
    .locked          (locked),
    .stop_req        (stop_req),
    .stop_en         (stop_en),
    .illegal_rst_req (illegal_rst_req),
    .rst_pin_en      (rst_pin_en)
);

// File: tb/sysopt_reg_test.sv
module sysopt_reg_test;

    logic       clk = 1'b0;
    logic       por_rst = 1'b0, lvd_rst = 1'b0, int_rst = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       locked, stop_req = 1'b0, illegal_rst_req;
    logic [1:0] wdog_tsel;
    logic       stop_en, bus_pin_alt, dbg_pin_en, rst_pin_en, rst_pullup_en;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    sysopt_reg uut (
        .clk(clk), .por_rst(por_rst), .lvd_rst(lvd_rst), .int_rst(int_rst),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .locked(locked), .stop_req(stop_req), .illegal_rst_req(illegal_rst_req),
        .wdog_tsel(wdog_tsel), .stop_en(stop_en), .bus_pin_alt(bus_pin_alt),
        .dbg_pin_en(dbg_pin_en), .rst_pin_en(rst_pin_en), .rst_pullup_en(rst_pullup_en)
    );

    // fields: [21:20] reset kind (0 none,1 por,2 lvd,3 int), [19] wr, [18:11] wdata,
    // [10] stop, [9:2] expected rdata, [1] expected lock, [0] expected illegal request
    localparam int NV = 17;
    localparam logic [21:0] VEC [NV] = '{
        {2'd1, 1'b0, 8'h00, 1'b0, 8'hC2, 1'b0, 1'b0},
        {2'd0, 1'b1, 8'hA7, 1'b0, 8'hA7, 1'b1, 1'b0},
        {2'd0, 1'b1, 8'h00, 1'b0, 8'hA7, 1'b1, 1'b0},
        {2'd2, 1'b0, 8'h00, 1'b0, 8'hC3, 1'b0, 1'b0},
        {2'd0, 1'b1, 8'hFF, 1'b0, 8'hF7, 1'b1, 1'b0},
        {2'd0, 1'b0, 8'h00, 1'b1, 8'hF7, 1'b1, 1'b0},
        {2'd0, 1'b0, 8'h00, 1'b0, 8'hF7, 1'b1, 1'b0},
        {2'd3, 1'b0, 8'h00, 1'b0, 8'hC3, 1'b0, 1'b0},
        {2'd0, 1'b0, 8'h00, 1'b1, 8'hC3, 1'b0, 1'b1},
        {2'd0, 1'b0, 8'h00, 1'b1, 8'hC3, 1'b0, 1'b0},
        {2'd0, 1'b1, 8'hC3, 1'b0, 8'hC3, 1'b1, 1'b0},
        {2'd0, 1'b1, 8'h00, 1'b0, 8'hC3, 1'b1, 1'b0},
        {2'd1, 1'b0, 8'h00, 1'b0, 8'hC2, 1'b0, 1'b0},
        {2'd0, 1'b1, 8'h20, 1'b1, 8'h20, 1'b1, 1'b1},
        {2'd0, 1'b0, 8'h00, 1'b1, 8'h20, 1'b1, 1'b0},
        {2'd0, 1'b0, 8'h00, 1'b0, 8'h20, 1'b1, 1'b0},
        {2'd0, 1'b0, 8'h00, 1'b1, 8'h20, 1'b1, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R10: every control output must follow the field it is decoded from
    task automatic check_outputs(input logic [7:0] rd);
        check("R10 wdog_tsel", {30'd0, wdog_tsel}, {30'd0, rd[7:6]});
        check("R10 stop_en", {31'd0, stop_en}, {31'd0, rd[5]});
        check("R10 bus_pin_alt", {31'd0, bus_pin_alt}, {31'd0, rd[2]});
        check("R10 dbg_pin_en", {31'd0, dbg_pin_en}, {31'd0, rd[1]});
        check("R10 rst_pin_en", {31'd0, rst_pin_en}, {31'd0, rd[0]});
        check("R10 rst_pullup_en", {31'd0, rst_pullup_en}, {31'd0, rd[0]});
    endtask

    task automatic step(input logic [1:0] rk, input logic wr, input logic [7:0] wd, input logic st);
        por_rst   = (rk == 2'd1);
        lvd_rst   = (rk == 2'd2);
        int_rst   = (rk == 2'd3);
        bus_wr    = wr;
        bus_wdata = wd;
        stop_req  = st;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // table: R1 R2 R3 R4 R6 R7 R9 R11
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][21:20], VEC[i][19], VEC[i][18:11], VEC[i][10]);
            check($sformatf("R1/R2/R3/R4/R6/R7 rdata step %0d", i), {24'd0, bus_rdata}, {24'd0, VEC[i][9:2]});
            check($sformatf("R1/R2/R3/R6 lock step %0d", i), {31'd0, locked}, {31'd0, VEC[i][1]});
            check($sformatf("R9/R11 illegal step %0d", i), {31'd0, illegal_rst_req}, {31'd0, VEC[i][0]});
            check_outputs(VEC[i][9:2]);
        end

        // R8: power-on together with low-voltage reset clears the reset-pin bit
        step(2'd1, 1'b0, 8'h00, 1'b0);
        step(2'd0, 1'b1, 8'h01, 1'b0);
        check("R7 setup rst_pin_en", {31'd0, rst_pin_en}, 32'd1);
        por_rst = 1'b1; lvd_rst = 1'b1; int_rst = 1'b0;
        bus_wr = 1'b0; stop_req = 1'b0;
        @(negedge clk);
        check("R8 por priority rdata", {24'd0, bus_rdata}, 32'hC2);
        check("R8 por priority lock", {31'd0, locked}, 32'd0);

        // R5: the spare bit is stored but drives no output
        step(2'd0, 1'b1, 8'h10, 1'b0);
        check("R5 spare readback", {24'd0, bus_rdata}, 32'h10);
        check_outputs(8'h00);
        step(2'd0, 1'b1, 8'h00, 1'b0);
        check("R5 spare held after lock", {24'd0, bus_rdata}, 32'h10);

        // R6: a reset input wins over a simultaneous write
        int_rst = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h3C;
        @(negedge clk);
        check("R6 reset beats write", {24'd0, bus_rdata}, 32'hC2);
        check("R6 reset beats write lock", {31'd0, locked}, 32'd0);
        step(2'd0, 1'b0, 8'h00, 1'b0);

        finish_run();
    end
endmodule